// File: doc/BRIEF.md
# Phase-Qualified Memory Map Decoder

This block turns the 16-bit address bus of an 8-bit processor into one-hot chip selects for the devices on the board. It has selects for seven 4K program PROM segments, two 1K scratch RAM segments, the two-address serial controller window and four peripheral register/gate windows. The decoder is purely combinational. Every select is qualified by the processor's second clock phase, so a peripheral only sees a register write or a gate read during the settled part of the bus cycle. The PROM output enable also depends on the read/write line, so the PROM drives the data bus only on reads.

The map is set by parameters. The defaults put RAM at the bottom of memory, the serial window and peripherals in the gap above it, and PROM at the very top, so that the reset vector falls inside a PROM segment. Elaboration checks reject regions that overlap, segment bases that are not aligned, and a PROM region that does not end at the top of the address space. While reset is high all outputs are held low.

Top module: `bus_select_decoder`

## Requirements
- R1: PROM occupies 0x9000–0xFFFF as seven 4K segments. `prom_cs_o[i]` selects 0x9000+i*0x1000 through 0x9FFF+i*0x1000 (i = 0..6).
- R2: RAM occupies 0x0000–0x07FF as two 1K segments. `ram_cs_o[0]` covers 0x0000–0x03FF and `ram_cs_o[1]` covers 0x0400–0x07FF.
- R3: `ser_cs_o` asserts for exactly the two addresses 0x8000 and 0x8001, and for no other address.
- R4: `per_cs_o[i]` selects 0x8400+i*0x100 through 0x84FF+i*0x100 (i = 0..3).
- R5: While `phi2_i` is low, every select and `prom_oe_o` are low, whatever the address.
- R6: `prom_oe_o` is high only when a PROM segment is selected and `rw_i` is 1 (read). On a write (`rw_i` = 0) the PROM select still asserts but `prom_oe_o` stays low.
- R7: At most one select asserts at a time. An address outside every region (for example 0x0800–0x7FFF) asserts none.
- R8: While `rst_i` is high, all outputs are low.
- R9: All outputs are active high and follow the inputs in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_i | input | 1 | Reset, active high; forces all outputs low |
| phi2_i | input | 1 | Processor second clock phase; qualifies every select |
| rw_i | input | 1 | Bus direction: 1 = read, 0 = write |
| addr_i | input | 16 | Processor address bus |
| prom_cs_o | output | 7 | PROM 4K segment selects |
| prom_oe_o | output | 1 | PROM output enable, read cycles only |
| ram_cs_o | output | 2 | RAM 1K segment selects |
| ser_cs_o | output | 1 | Serial controller select |
| per_cs_o | output | 4 | Peripheral register/gate window selects |

## Verification
The bench sweeps every 1K boundary of the address space. At each boundary it drives the last address below it, the boundary address itself and the one above, with both phase levels and both bus directions. Off-by-one region limits and wrong segment indexing show up at those points, and phase-low cycles separate real qualification from raw decoding. Extra patterns probe the serial pair and the byte on each side of it, the first and last byte of each peripheral window, and PROM writes, which separate select from output enable. Addresses applied under reset show that reset overrides an otherwise valid decode.

// File: rtl/bus_select_pkg.sv
package bus_select_pkg;

   localparam int ADDR_W_DEF     = 16;

   localparam int RAM_BASE_DEF   = 'h0000;
   localparam int RAM_SEGB_DEF   = 10;
   localparam int RAM_SEGS_DEF   = 2;

   localparam int SER_BASE_DEF   = 'h8000;
   localparam int SER_SEGB_DEF   = 1;

   localparam int PER_BASE_DEF   = 'h8400;
   localparam int PER_SEGB_DEF   = 8;
   localparam int PER_SEGS_DEF   = 4;

   localparam int PROM_BASE_DEF  = 'h9000;
   localparam int PROM_SEGB_DEF  = 12;
   localparam int PROM_SEGS_DEF  = 7;

   // first address past a region of n segments of 2**seg_bits bytes
   function automatic int region_end(input int base, input int seg_bits, input int n);
      return base + (n << seg_bits);
   endfunction

endpackage

// File: rtl/seg_decoder.sv
module seg_decoder #(
   parameter int ADDR_W   = 16,
   parameter int BASE     = 0,
   parameter int SEG_BITS = 10,
   parameter int SEG_N    = 2
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [SEG_N-1:0]  sel_o
);

   localparam int SEG_SIZE = 1 << SEG_BITS;
   localparam int SPAN     = SEG_N * SEG_SIZE;
   localparam int EXT_W    = ADDR_W + 1;

   if (SEG_N < 1) begin : g_bad_count
      $error("seg_decoder: SEG_N must be at least 1");
   end
   if (SEG_BITS < 0 || SEG_BITS > ADDR_W) begin : g_bad_bits
      $error("seg_decoder: SEG_BITS out of range");
   end
   if ((BASE % SEG_SIZE) != 0) begin : g_bad_align
      $error("seg_decoder: BASE not aligned to the segment size");
   end
   if (BASE + SPAN > (1 << ADDR_W)) begin : g_bad_span
      $error("seg_decoder: region runs past the address space");
   end

   logic [EXT_W-1:0] addr_ext;
   assign addr_ext = {1'b0, addr_i};

   for (genvar i = 0; i < SEG_N; i++) begin : g_seg
      localparam logic [EXT_W-1:0] LO = EXT_W'(BASE + i * SEG_SIZE);
      localparam logic [EXT_W-1:0] HI = EXT_W'(BASE + (i + 1) * SEG_SIZE);
      assign sel_o[i] = (addr_ext >= LO) && (addr_ext < HI);
   end

endmodule

// File: rtl/phase_gate.sv
module phase_gate #(
   parameter int N = 8
) (
   input  logic         rst_i,
   input  logic         phi2_i,
   input  logic [N-1:0] raw_i,
   output logic [N-1:0] gated_o
);

   if (N < 1) begin : g_bad_n
      $error("phase_gate: N must be at least 1");
   end

   logic qualify;
   assign qualify = phi2_i & ~rst_i;

   for (genvar i = 0; i < N; i++) begin : g_bit
      assign gated_o[i] = raw_i[i] & qualify;
   end

endmodule

// File: rtl/bus_select_decoder.sv
module bus_select_decoder
   import bus_select_pkg::*;
#(
   parameter int ADDR_W    = ADDR_W_DEF,
   parameter int RAM_BASE  = RAM_BASE_DEF,
   parameter int RAM_SEGB  = RAM_SEGB_DEF,
   parameter int RAM_SEGS  = RAM_SEGS_DEF,
   parameter int SER_BASE  = SER_BASE_DEF,
   parameter int SER_SEGB  = SER_SEGB_DEF,
   parameter int PER_BASE  = PER_BASE_DEF,
   parameter int PER_SEGB  = PER_SEGB_DEF,
   parameter int PER_SEGS  = PER_SEGS_DEF,
   parameter int PROM_BASE = PROM_BASE_DEF,
   parameter int PROM_SEGB = PROM_SEGB_DEF,
   parameter int PROM_SEGS = PROM_SEGS_DEF
) (
   input  logic                 rst_i,
   input  logic                 phi2_i,
   input  logic                 rw_i,
   input  logic [ADDR_W-1:0]    addr_i,
   output logic [PROM_SEGS-1:0] prom_cs_o,
   output logic                 prom_oe_o,
   output logic [RAM_SEGS-1:0]  ram_cs_o,
   output logic                 ser_cs_o,
   output logic [PER_SEGS-1:0]  per_cs_o
);

   localparam int RAM_END  = region_end(RAM_BASE, RAM_SEGB, RAM_SEGS);
   localparam int SER_END  = region_end(SER_BASE, SER_SEGB, 1);
   localparam int PER_END  = region_end(PER_BASE, PER_SEGB, PER_SEGS);
   localparam int PROM_END = region_end(PROM_BASE, PROM_SEGB, PROM_SEGS);
   localparam int TOTAL    = PROM_SEGS + RAM_SEGS + 1 + PER_SEGS;

   // map ordering: RAM low, I/O in the gap, PROM ending at the top
   if (RAM_END > SER_BASE) begin : g_ovl_ram
      $error("bus_select_decoder: RAM overlaps serial window");
   end
   if (SER_END > PER_BASE) begin : g_ovl_ser
      $error("bus_select_decoder: serial window overlaps peripherals");
   end
   if (PER_END > PROM_BASE) begin : g_ovl_per
      $error("bus_select_decoder: peripherals overlap PROM");
   end
   if (PROM_END != (1 << ADDR_W)) begin : g_prom_top
      $error("bus_select_decoder: PROM must end at the top so the reset vector is in PROM");
   end

   logic [PROM_SEGS-1:0] prom_raw;
   logic [RAM_SEGS-1:0]  ram_raw;
   logic [0:0]           ser_raw;
   logic [PER_SEGS-1:0]  per_raw;
   logic [TOTAL-1:0]     raw_all;
   logic [TOTAL-1:0]     gated_all;

   seg_decoder #(
      .ADDR_W(ADDR_W), .BASE(PROM_BASE), .SEG_BITS(PROM_SEGB), .SEG_N(PROM_SEGS)
   ) u_prom_dec (
      .addr_i(addr_i),
      .sel_o (prom_raw)
   );

   seg_decoder #(
      .ADDR_W(ADDR_W), .BASE(RAM_BASE), .SEG_BITS(RAM_SEGB), .SEG_N(RAM_SEGS)
   ) u_ram_dec (
      .addr_i(addr_i),
      .sel_o (ram_raw)
   );

   seg_decoder #(
      .ADDR_W(ADDR_W), .BASE(SER_BASE), .SEG_BITS(SER_SEGB), .SEG_N(1)
   ) u_ser_dec (
      .addr_i(addr_i),
      .sel_o (ser_raw)
   );

   seg_decoder #(
      .ADDR_W(ADDR_W), .BASE(PER_BASE), .SEG_BITS(PER_SEGB), .SEG_N(PER_SEGS)
   ) u_per_dec (
      .addr_i(addr_i),
      .sel_o (per_raw)
   );

   assign raw_all = {prom_raw, ram_raw, ser_raw, per_raw};

   phase_gate #(
      .N(TOTAL)
   ) u_gate (
      .rst_i  (rst_i),
      .phi2_i (phi2_i),
      .raw_i  (raw_all),
      .gated_o(gated_all)
   );

   assign {prom_cs_o, ram_cs_o, ser_cs_o, per_cs_o} = gated_all;

   // PROM drives the data bus only on read cycles
   assign prom_oe_o = rw_i & (|prom_cs_o);

   always_comb begin
      assert_one_hot_R7: assert ($onehot0({prom_cs_o, ram_cs_o, ser_cs_o, per_cs_o}))
         else $error("more than one select active");
      assert_phase_gate_R5: assert (phi2_i || !(|{prom_cs_o, prom_oe_o, ram_cs_o, ser_cs_o, per_cs_o}))
         else $error("select active while phase-2 low");
      assert_reset_quiet_R8: assert (!rst_i || !(|{prom_cs_o, prom_oe_o, ram_cs_o, ser_cs_o, per_cs_o}))
         else $error("output active during reset");
      assert_oe_read_R6: assert (rw_i || !prom_oe_o)
         else $error("PROM output enable on a write cycle");
      assert_ser_pair_R3: assert (!ser_cs_o || (addr_i[ADDR_W-1:SER_SEGB] == (ADDR_W-SER_SEGB)'(SER_BASE >> SER_SEGB)))
         else $error("serial select outside its address pair");
   end

endmodule

// File: tb/bus_select_decoder_bench.sv
module bus_select_decoder_bench;

   logic        clk = 1'b0;
   logic        rst_i, phi2_i, rw_i;
   logic [15:0] addr_i;
   logic [6:0]  prom_cs_o;
   logic        prom_oe_o;
   logic [1:0]  ram_cs_o;
   logic        ser_cs_o;
   logic [3:0]  per_cs_o;

   int total = 0;
   int bad   = 0;
   logic [14:0] exp_q[$];
   bit          done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   bus_select_decoder u_bus_select_decoder (
      .rst_i(rst_i), .phi2_i(phi2_i), .rw_i(rw_i), .addr_i(addr_i),
      .prom_cs_o(prom_cs_o), .prom_oe_o(prom_oe_o), .ram_cs_o(ram_cs_o),
      .ser_cs_o(ser_cs_o), .per_cs_o(per_cs_o)
   );

   // reference map; packing {prom[6:0], oe, ram[1:0], ser, per[3:0]}
   function automatic logic [14:0] ref_map(input logic [15:0] a, input logic p,
                                          input logic r, input logic rs);
      logic [6:0] pr = '0;
      logic [1:0] rm = '0;
      logic       sr = 1'b0;
      logic [3:0] pe = '0;
      logic       oe;
      int ai = int'(a);
      if (ai >= 'h9000) pr[(ai - 'h9000) / 'h1000] = 1'b1;      // R1
      if (ai < 'h0800)  rm[ai / 'h400] = 1'b1;                  // R2
      if (ai == 'h8000 || ai == 'h8001) sr = 1'b1;              // R3
      if (ai >= 'h8400 && ai < 'h8800) pe[(ai - 'h8400) / 'h100] = 1'b1; // R4
      if (!p || rs) begin                                       // R5, R8
         pr = '0; rm = '0; sr = 1'b0; pe = '0;
      end
      oe = r && (|pr);                                          // R6
      return {pr, oe, rm, sr, pe};
   endfunction

   function automatic string req_of(input logic [14:0] d, input logic p, input logic rs);
      if (rs) return "R8";
      if (!p) return "R5";
      if (d[7]) return "R6";
      if (d[14:8] != 0) return "R1";
      if (d[6:5] != 0) return "R2";
      if (d[4]) return "R3";
      return "R4";
   endfunction

   // driver: apply at posedge and queue the expected outputs
   task automatic drive(input logic [15:0] a, input logic p, input logic r, input logic rs);
      @(posedge clk);
      addr_i = a; phi2_i = p; rw_i = r; rst_i = rs;
      exp_q.push_back(ref_map(a, p, r, rs));
   endtask

   // monitor: same-cycle comparison at the falling edge (R9, R7 via one-hot reference)
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            logic [14:0] exp_v, got_v;
            exp_v = exp_q.pop_front();
            got_v = {prom_cs_o, prom_oe_o, ram_cs_o, ser_cs_o, per_cs_o};
            total++;
            if (got_v !== exp_v) begin
               bad++;
               $display("FAIL %s R9 addr=%h phi2=%b rw=%b rst=%b got=%b exp=%b",
                        req_of(got_v ^ exp_v, phi2_i, rst_i), addr_i, phi2_i, rw_i, rst_i,
                        got_v, exp_v);
            end
         end
      end
   end

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin
      rst_i = 1'b1; phi2_i = 1'b0; rw_i = 1'b1; addr_i = '0;
      // R8: reset state, and reset overriding valid decodes
      drive(16'h0000, 1'b0, 1'b1, 1'b1);
      drive(16'hFFFC, 1'b1, 1'b1, 1'b1);
      drive(16'h8000, 1'b1, 1'b0, 1'b1);
      drive(16'h0400, 1'b1, 1'b1, 1'b1);
      // R1 R2 R5 R6 R7: sweep of every 1K boundary, both phases and directions
      for (int k = 0; k < 64; k++) begin
         for (int d = -1; d <= 1; d++) begin
            for (int p = 0; p < 2; p++) begin
               for (int r = 0; r < 2; r++) begin
                  drive(16'((k * 1024 + d) & 'hFFFF), p[0], r[0], 1'b0);
               end
            end
         end
      end
      // R3: serial pair and its neighbours
      drive(16'h7FFF, 1'b1, 1'b1, 1'b0);
      drive(16'h8000, 1'b1, 1'b1, 1'b0);
      drive(16'h8001, 1'b1, 1'b0, 1'b0);
      drive(16'h8002, 1'b1, 1'b1, 1'b0);
      drive(16'h8001, 1'b0, 1'b1, 1'b0);
      // R4: first and last byte of each peripheral window
      for (int i = 0; i < 4; i++) begin
         drive(16'(16'h8400 + i * 'h100), 1'b1, 1'b1, 1'b0);
         drive(16'(16'h84FF + i * 'h100), 1'b1, 1'b0, 1'b0);
      end
      drive(16'h83FF, 1'b1, 1'b1, 1'b0);
      drive(16'h8800, 1'b1, 1'b1, 1'b0);
      // R1 R6: last byte of each PROM segment, read then write
      for (int i = 0; i < 7; i++) begin
         drive(16'(16'h9FFF + i * 'h1000), 1'b1, 1'b1, 1'b0);
         drive(16'(16'h9FFF + i * 'h1000), 1'b1, 1'b0, 1'b0);
      end
      // R7: undecoded gap
      drive(16'h0800, 1'b1, 1'b1, 1'b0);
      drive(16'h4321, 1'b1, 1'b1, 1'b0);
      drive(16'h8FFF, 1'b1, 1'b1, 1'b0);
      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule